// File: doc/BRIEF.md
# Zero-Wait Port Read Mailbox

This block serves input-port reads from an 8-bit CPU without any wait state. A helper microcontroller keeps a bank of sixteen 8-bit entries filled ahead of time, one entry per readable port. When the CPU issues an I/O read, the entry picked by the low four address bits is placed on the read data output in the same cycle, through combinational logic only. The controller is never asked for the data at read time.

On the controller side, a write presents a 4-bit entry index and an 8-bit value while a load strobe is high. The value is captured at the next rising clock edge into that entry alone. An entry keeps its value until the controller overwrites it, so the CPU may read it any number of times. When a load and a CPU read target the same entry in the same cycle, the read returns the value being loaded, as a transparent latch would. The tristate data bus is modelled as a data vector plus an output-enable.

Top module: `port_mailbox`

## Requirements
- R1: After reset, every one of the 16 entries reads as 0x00.
- R2: `rd_oe` is 1 exactly when `iorq_n` and `rd_n` are both 0, and 0 otherwise.
- R3: While `rd_oe` is 0, `rd_data` is 0x00.
- R4: While a read is active, `rd_data` equals the entry indexed by `cpu_addr` in the same cycle, with no clock edge in between.
- R5: When `ld_stb` is 1 at a rising edge of `clk`, the entry indexed by `ld_idx` takes `ld_data`, and all other entries are unchanged.
- R6: An entry holds its value across any number of reads and any number of cycles until it is loaded again.
- R7: If a read is active and `ld_stb` is 1 with `ld_idx` equal to `cpu_addr`, `rd_data` equals `ld_data` in that cycle; with unequal indices the read returns the stored entry.
- R8: A rising edge with `ld_stb` at 0 changes no entry, whatever `ld_idx` and `ld_data` hold.
- R9: At most one entry is selected onto the read path at any time, and none when no read is active.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the load side |
| rst_n | input | 1 | Asynchronous active-low reset, clears all entries |
| ld_stb | input | 1 | Controller load strobe, active high |
| ld_idx | input | 4 | Entry index for a load |
| ld_data | input | 8 | Value to load |
| cpu_addr | input | 4 | Low CPU address bits selecting the entry to read |
| iorq_n | input | 1 | CPU I/O request, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| rd_data | output | 8 | Read data, 0x00 when not enabled |
| rd_oe | output | 1 | Output-enable for the CPU data bus |

## Verification
The assertions assume that `ld_stb`, `ld_idx` and `ld_data` are settled before each rising edge and that reset is released while the strobe is low, so that the captured value is the one on the pins at the edge. The CPU-side inputs may change at any time, since the read path holds no state. The stimulus changes every input just after a falling edge, keeps the strobe low during reset, and then mixes directed loads, unstrobed writes, idle strobe patterns and same-index collisions with a long random run.

// File: rtl/port_mailbox_pkg.sv
package port_mailbox_pkg;
  localparam int unsigned DEF_IDX_W  = 4;
  localparam int unsigned DEF_DATA_W = 8;

  // A CPU read is active when both active-low strobes are low.
  function automatic logic read_active(input logic iorq_n, input logic rd_n);
    return (iorq_n == 1'b0) && (rd_n == 1'b0);
  endfunction

  // A same-cycle load wins over the stored value for the entry it targets.
  function automatic logic pick_incoming(input logic stb, input logic hit);
    return stb && hit;
  endfunction
endpackage

// File: rtl/pmb_decoder.sv
module pmb_decoder #(
  parameter int unsigned IDX_W = 4,
  localparam int unsigned N = 1 << IDX_W
) (
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic [N-1:0]     sel
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_line
      assign sel[g] = en && (idx == IDX_W'(g));
    end
  endgenerate

  always_comb begin
    a_sel_onehot_r9: assert ($onehot0(sel));
    if (!en) a_sel_idle_r9: assert (sel == '0);
  end
endmodule

// File: rtl/pmb_bank.sv
module pmb_bank #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned N = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q [N]
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         q[g] <= '0;
        else if (wr_sel[g]) q[g] <= wr_data;
      end

      p_load_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel[g] |=> q[g] == $past(wr_data));
      p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel[g] |=> $stable(q[g]));
    end
  endgenerate
endmodule

// File: rtl/pmb_read_drive.sv
module pmb_read_drive #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned N = 1 << IDX_W
) (
  input  logic              rd_act,
  input  logic [N-1:0]      rd_sel,
  input  logic              ld_stb,
  input  logic [N-1:0]      wr_sel,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [DATA_W-1:0] q [N],
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  import port_mailbox_pkg::*;

  logic [DATA_W-1:0] word [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_word
      assign word[g] = pick_incoming(ld_stb, wr_sel[g]) ? ld_data : q[g];
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++) begin
      if (rd_sel[i]) rd_data = rd_data | word[i];
    end
  end

  assign rd_oe = rd_act;

  always_comb begin
    if (!rd_oe) a_quiet_bus_r3: assert (rd_data == '0);
  end
endmodule

// File: rtl/port_mailbox.sv
module port_mailbox #(
  parameter int unsigned IDX_W  = port_mailbox_pkg::DEF_IDX_W,
  parameter int unsigned DATA_W = port_mailbox_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_stb,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  cpu_addr,
  input  logic              iorq_n,
  input  logic              rd_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_oe
);
  import port_mailbox_pkg::*;
  localparam int unsigned N = 1 << IDX_W;

  logic              rd_act;
  logic [N-1:0]      rd_sel;
  logic [N-1:0]      wr_sel;
  logic [DATA_W-1:0] q [N];

  assign rd_act = read_active(iorq_n, rd_n);

  pmb_decoder #(.IDX_W(IDX_W)) u_wr_dec (
    .en(ld_stb), .idx(ld_idx), .sel(wr_sel)
  );

  pmb_decoder #(.IDX_W(IDX_W)) u_rd_dec (
    .en(rd_act), .idx(cpu_addr), .sel(rd_sel)
  );

  pmb_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(ld_data), .q(q)
  );

  pmb_read_drive #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_drive (
    .rd_act(rd_act), .rd_sel(rd_sel), .ld_stb(ld_stb), .wr_sel(wr_sel),
    .ld_data(ld_data), .q(q), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  p_oe_follows_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oe == (!iorq_n && !rd_n));
  p_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_oe && ld_stb && (ld_idx == cpu_addr)) |-> rd_data == ld_data);
  p_read_after_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb ##1 (rd_oe && !ld_stb && cpu_addr == $past(ld_idx)))
      |-> rd_data == $past(ld_data));
endmodule

// File: tb/tb_port_mailbox.sv
module tb_port_mailbox;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_stb = 1'b0;
  logic [3:0] ld_idx = '0;
  logic [7:0] ld_data = '0;
  logic [3:0] cpu_addr = '0;
  logic       iorq_n = 1'b1;
  logic       rd_n = 1'b1;
  logic [7:0] rd_data;
  logic       rd_oe;

  int tests = 0;
  int fails = 0;
  logic [7:0] model [16];

  always #10 clk = ~clk;

  port_mailbox dut (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_idx(ld_idx),
    .ld_data(ld_data), .cpu_addr(cpu_addr), .iorq_n(iorq_n), .rd_n(rd_n),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: oe/data actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock cycle: drive after the falling edge, check mid-low phase,
  // then let the rising edge commit any load into the reference model.
  task automatic cyc(input string req, input logic stb, input logic [3:0] li,
                     input logic [7:0] ld, input logic iq, input logic rd,
                     input logic [3:0] ad);
    logic [7:0] e_data;
    logic       e_oe;
    @(negedge clk);
    ld_stb = stb; ld_idx = li; ld_data = ld;
    iorq_n = iq; rd_n = rd; cpu_addr = ad;
    #5;
    e_oe = !iq && !rd;
    if (!e_oe) e_data = 8'h00;
    else if (stb && li == ad) e_data = ld;
    else e_data = model[ad];
    check(req, {rd_oe, rd_data}, {e_oe, e_data});
    @(posedge clk);
    if (stb && rst_n) model[li] = ld;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(posedge clk);
    #5 check("R3 reset idle", {rd_oe, rd_data}, 9'h000);
    @(negedge clk); rst_n = 1'b1;

    // R1: all entries zero after reset
    for (int i = 0; i < 16; i++) cyc("R1", 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'(i));

    // R2/R3: partial strobes do not enable the bus
    cyc("R2 iorq only", 1'b0, 4'h0, 8'h00, 1'b0, 1'b1, 4'h3);
    cyc("R2 rd only",   1'b0, 4'h0, 8'h00, 1'b1, 1'b0, 4'h3);
    cyc("R3 idle",      1'b0, 4'h0, 8'h00, 1'b1, 1'b1, 4'h3);

    // R5: load each entry with a distinct value, idle bus
    for (int i = 0; i < 16; i++)
      cyc("R5 load", 1'b1, 4'(i), 8'(8'h5A ^ (i * 17)), 1'b1, 1'b1, 4'h0);
    // R4: read all back
    for (int i = 0; i < 16; i++) cyc("R4", 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'(i));

    // R5: single load leaves others unchanged
    cyc("R5 single", 1'b1, 4'h7, 8'hC3, 1'b1, 1'b1, 4'h0);
    for (int i = 0; i < 16; i++) cyc("R5 others", 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'(i));

    // R8: data and index toggling with strobe low
    for (int i = 0; i < 16; i++) cyc("R8 nostb", 1'b0, 4'(i), 8'hFF, 1'b1, 1'b1, 4'h0);
    for (int i = 0; i < 16; i++) cyc("R8", 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'(i));

    // R6: repeated reads over many cycles
    for (int i = 0; i < 20; i++) cyc("R6", 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'h7);

    // R7: same-index collision and different-index collision
    cyc("R7 same", 1'b1, 4'h2, 8'h99, 1'b0, 1'b0, 4'h2);
    cyc("R7 after", 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'h2);
    cyc("R7 diff", 1'b1, 4'h4, 8'h11, 1'b0, 1'b0, 4'h5);
    cyc("R7 diff after", 1'b0, 4'h0, 8'h00, 1'b0, 1'b0, 4'h4);

    // R9 and mixed: random run
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc("R9 random", r[0], r[4:1], r[12:5], r[13] & r[14], r[15] & r[16], r[20:17]);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule